// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a four-bank synchronous DRAM on every rising clock edge. It turns each sample into exactly one named command, reported on a one-hot vector, and keeps a model of which banks hold an open row. It also tracks whether the device is running, powered down, clock-suspended or in self refresh. Typical uses are a protocol monitor next to a memory controller, or the front end of a behavioural memory model. Illegal requests are flagged on an error output and leave every bank unchanged.

The previous-cycle CKE level is held by the device state machine, so it does not need a separate register. The two running states (`ST_IDLE` with no open bank, `ST_ACTIVE` with at least one) imply CKE was high. The three low-power states (`ST_PWRDN`, `ST_SUSPEND`, `ST_SELFREF`) imply CKE was low. The transitions are: run to run (`ST_IDLE`/`ST_ACTIVE`, chosen from the next bank flags) on every CKE-high edge. Run to `ST_SELFREF` on a legal CKE-falling refresh pattern. Run to `ST_SUSPEND` on CKE falling during a burst. Run to `ST_PWRDN` on any other CKE fall. Any low-power state stays put while CKE stays low, and returns to `ST_IDLE` or `ST_ACTIVE`, chosen from the bank flags, when CKE rises.

An internal burst counter of `BURST_LEN` beats starts on each accepted read or write. It advances only on edges where CKE is sampled high, and closes the addressed bank on its last beat when auto-precharge was requested. All outputs are registered and change on the same edge that samples the pins.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With CKE high in a running state, the sampled pins (cs_n, ras_n, cas_n, we_n) select one bit of `cmd_vec`: 1xxx deselect = bit 0, 0111 no-op = bit 1, 0011 activate = bit 2, 0101 read = bit 3, 0100 write = bit 4, 0010 precharge = bit 5, 0000 mode set = bit 6, 0001 auto refresh = bit 7. The result appears after the sampling edge. Deselect changes no state.
- R2: The pattern 0110 is not a supported command. It reports bit 1 together with `cmd_err` and changes no state.
- R3: Activate is accepted only when the addressed bank is closed and no auto-precharge burst targets it. It then sets that bank's bit in `bank_open` (bank n = bit n) and moves the device to `ST_ACTIVE` (`dev_active`=1). Otherwise it raises `cmd_err` and leaves the banks unchanged.
- R4: Read or write is accepted only to an open bank while no auto-precharge burst is pending. Otherwise it raises `cmd_err`. An accepted command starts a `BURST_LEN`-beat burst (`burst_busy`=1), and `ap_flag` pulses for one cycle when a10 was high.
- R5: Precharge is legal in any bank state. With a10 low it closes the bank on ba, and with a10 high it closes all banks. `pre_mask` shows the closed set for that one cycle and is zero otherwise.
- R6: A burst ends after `BURST_LEN` CKE-high edges following its command. An auto-precharge burst closes its bank on that last edge.
- R7: Mode set and auto refresh are accepted only with all banks closed and no burst in progress. Otherwise they raise `cmd_err` without changing the banks.
- R8: CKE falling with the refresh pattern (cs_n low, 0001), all banks closed and no burst, reports bit 8 and enters self refresh (`in_selfref`). The same pattern in any other condition raises `cmd_err` and is handled as in R9.
- R9: Any other CKE fall reports bit 12 and enters clock suspend (`in_suspend`) if a burst is in progress. The burst counter is frozen while CKE is low. With no burst in progress it reports bit 10 and enters power-down (`in_pwrdn`). No command on that edge is executed.
- R10: In a low-power state, CKE low reports bit 14 (hold). CKE high reports the exit code: self refresh bit 9, power-down bit 11, suspend bit 13. The device then resumes `ST_IDLE` or `ST_ACTIVE` according to the preserved bank flags.
- R11: After reset `cmd_vec`, `bank_open`, `pre_mask` and every flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| ba | input | 2 | Bank select |
| cmd_vec | output | 15 | One-hot decoded command |
| cmd_err | output | 1 | Command illegal in current state |
| ap_flag | output | 1 | Accepted read/write requested auto-precharge |
| pre_mask | output | 4 | Banks closed by a precharge command |
| bank_open | output | 4 | Per-bank open-row flags |
| dev_active | output | 1 | Device in ST_ACTIVE |
| in_pwrdn | output | 1 | Device in ST_PWRDN |
| in_suspend | output | 1 | Device in ST_SUSPEND |
| in_selfref | output | 1 | Device in ST_SELFREF |
| burst_busy | output | 1 | Burst in progress |

## Verification
Every decode result (`cmd_vec`, `cmd_err`, `ap_flag`, `pre_mask`, the state flags and `bank_open`) is due right after the edge that samples the pins. The bench therefore drives pins at a falling edge and checks at the next falling edge. Burst ends are due `BURST_LEN` CKE-high edges after the read or write, and frozen edges inside a suspend do not count. The bench counts those edges one by one and checks the beat before the end as well as the end itself, so an early or late bank close is caught.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        P_DSEL, P_NOP, P_ACT, P_RD, P_WR, P_PRE, P_MRS, P_REF, P_BAD
    } pin_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACTIVE, ST_PWRDN, ST_SUSPEND, ST_SELFREF
    } dev_state_e;

    localparam int NCMD        = 15;
    localparam int CI_DESEL    = 0;
    localparam int CI_NOP      = 1;
    localparam int CI_ACT      = 2;
    localparam int CI_RD       = 3;
    localparam int CI_WR       = 4;
    localparam int CI_PRE      = 5;
    localparam int CI_MRS      = 6;
    localparam int CI_REF      = 7;
    localparam int CI_SREF_IN  = 8;
    localparam int CI_SREF_OUT = 9;
    localparam int CI_PD_IN    = 10;
    localparam int CI_PD_OUT   = 11;
    localparam int CI_SUS_IN   = 12;
    localparam int CI_SUS_OUT  = 13;
    localparam int CI_HOLD     = 14;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    output pin_op_e op
);

    always_comb begin
        if (cs_n) begin
            op = P_DSEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  op = P_NOP;
                3'b011:  op = P_ACT;
                3'b101:  op = P_RD;
                3'b100:  op = P_WR;
                3'b010:  op = P_PRE;
                3'b000:  op = P_MRS;
                3'b001:  op = P_REF;
                default: op = P_BAD;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_burst.sv
module sdcmd_burst #(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NBANK),
    localparam int CW       = $clog2(BURST_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            start,
    input  logic            start_ap,
    input  logic [BA_W-1:0] start_bank,
    output logic            busy,
    output logic            ap_pend,
    output logic [BA_W-1:0] ap_bank,
    output logic            ap_close
);

    logic [CW-1:0]   left_q;
    logic            ap_q;
    logic [BA_W-1:0] bank_q;

    assign busy     = (left_q != '0);
    assign ap_pend  = ap_q;
    assign ap_bank  = bank_q;
    assign ap_close = adv && ap_q && !start && (left_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            ap_q   <= 1'b0;
            bank_q <= '0;
        end else if (start) begin
            left_q <= CW'(BURST_LEN);
            ap_q   <= start_ap;
            bank_q <= start_bank;
        end else if (adv && busy) begin
            left_q <= left_q - CW'(1);
            if (left_q == CW'(1)) begin
                ap_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track #(
    parameter int NBANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] set_mask,
    input  logic [NBANK-1:0] clr_mask,
    output logic [NBANK-1:0] open_q,
    output logic [NBANK-1:0] open_nxt
);

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        assign open_nxt[gi] = (open_q[gi] && !clr_mask[gi]) || set_mask[gi];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[gi] <= 1'b0;
            end else begin
                open_q[gi] <= open_nxt[gi];
            end
        end

        // R3: an activate only ever lands on a closed bank
        a_r3_set_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[gi] |-> !open_q[gi]);

        // R5: open and close never target the same bank in one cycle
        a_r5_no_set_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !(set_mask[gi] && clr_mask[gi]));
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             a10,
    input  logic [BA_W-1:0]  ba,
    output logic [NCMD-1:0]  cmd_vec,
    output logic             cmd_err,
    output logic             ap_flag,
    output logic [NBANK-1:0] pre_mask,
    output logic [NBANK-1:0] bank_open,
    output logic             dev_active,
    output logic             in_pwrdn,
    output logic             in_suspend,
    output logic             in_selfref,
    output logic             burst_busy
);

    pin_op_e          op;
    dev_state_e       state_q, state_d, tgt;
    logic [NBANK-1:0] bank_nxt, ba_hot, act_set, pre_clr, ap_mask;
    logic             busy, ap_pend, ap_close, start, start_ap, err_d;
    logic [BA_W-1:0]  ap_bank;
    int unsigned      idx_d;

    sdcmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
    );

    sdcmd_burst #(.NBANK(NBANK), .BURST_LEN(BURST_LEN)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (cke),
        .start     (start),
        .start_ap  (start_ap),
        .start_bank(ba),
        .busy      (busy),
        .ap_pend   (ap_pend),
        .ap_bank   (ap_bank),
        .ap_close  (ap_close)
    );

    assign ba_hot  = NBANK'(1) << ba;
    assign ap_mask = ap_close ? (NBANK'(1) << ap_bank) : '0;

    sdcmd_bank_track #(.NBANK(NBANK)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(act_set),
        .clr_mask(pre_clr | ap_mask),
        .open_q  (bank_open),
        .open_nxt(bank_nxt)
    );

    // command choice, legality and target class
    always_comb begin
        idx_d    = CI_NOP;
        err_d    = 1'b0;
        act_set  = '0;
        pre_clr  = '0;
        start    = 1'b0;
        start_ap = 1'b0;
        tgt      = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE: begin
                if (cke) begin
                    unique case (op)
                        P_DSEL: idx_d = CI_DESEL;
                        P_NOP:  idx_d = CI_NOP;
                        P_ACT: begin
                            idx_d = CI_ACT;
                            if (bank_open[ba] || (ap_pend && ap_bank == ba)) begin
                                err_d = 1'b1;
                            end else begin
                                act_set = ba_hot;
                            end
                        end
                        P_RD, P_WR: begin
                            idx_d = (op == P_RD) ? CI_RD : CI_WR;
                            if (!bank_open[ba] || ap_pend) begin
                                err_d = 1'b1;
                            end else begin
                                start    = 1'b1;
                                start_ap = a10;
                            end
                        end
                        P_PRE: begin
                            idx_d   = CI_PRE;
                            pre_clr = a10 ? '1 : ba_hot;
                        end
                        P_MRS, P_REF: begin
                            idx_d = (op == P_MRS) ? CI_MRS : CI_REF;
                            err_d = (bank_open != '0) || busy;
                        end
                        default: begin
                            idx_d = CI_NOP;
                            err_d = 1'b1;
                        end
                    endcase
                end else if (op == P_REF && bank_open == '0 && !busy) begin
                    idx_d = CI_SREF_IN;
                    tgt   = ST_SELFREF;
                end else begin
                    err_d = (op == P_REF);
                    idx_d = busy ? CI_SUS_IN : CI_PD_IN;
                    tgt   = busy ? ST_SUSPEND : ST_PWRDN;
                end
            end
            ST_PWRDN: begin
                idx_d = cke ? CI_PD_OUT : CI_HOLD;
                tgt   = cke ? ST_IDLE : ST_PWRDN;
            end
            ST_SUSPEND: begin
                idx_d = cke ? CI_SUS_OUT : CI_HOLD;
                tgt   = cke ? ST_IDLE : ST_SUSPEND;
            end
            ST_SELFREF: begin
                idx_d = cke ? CI_SREF_OUT : CI_HOLD;
                tgt   = cke ? ST_IDLE : ST_SELFREF;
            end
            default: begin
                idx_d = CI_NOP;
                tgt   = ST_IDLE;
            end
        endcase
    end

    // running target resolves to idle or active from the next bank flags
    always_comb begin
        if (tgt == ST_IDLE) begin
            state_d = (bank_nxt != '0) ? ST_ACTIVE : ST_IDLE;
        end else begin
            state_d = tgt;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_vec  <= '0;
            cmd_err  <= 1'b0;
            ap_flag  <= 1'b0;
            pre_mask <= '0;
        end else begin
            cmd_vec  <= NCMD'(1) << idx_d;
            cmd_err  <= err_d;
            ap_flag  <= start && start_ap;
            pre_mask <= pre_clr;
        end
    end

    assign dev_active = (state_q == ST_ACTIVE);
    assign in_pwrdn   = (state_q == ST_PWRDN);
    assign in_suspend = (state_q == ST_SUSPEND);
    assign in_selfref = (state_q == ST_SELFREF);
    assign burst_busy = busy;

    // R7: a refused command leaves every bank flag as it was
    a_r7_err_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !$past(ap_close)) |-> $stable(bank_open));

    // R8: self refresh is only ever entered with every bank closed
    a_r8_selfref_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_selfref) |-> (bank_open == '0 && !burst_busy));

    // R9: clock suspend always holds a frozen, unfinished burst
    a_r9_suspend_keeps_burst: assert property (@(posedge clk) disable iff (!rst_n)
        in_suspend |-> burst_busy);

    // R4: the auto-precharge pulse only follows a read or write code
    a_r4_ap_on_rdwr: assert property (@(posedge clk) disable iff (!rst_n)
        ap_flag |-> (cmd_vec[CI_RD] || cmd_vec[CI_WR]));

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;

    localparam logic [3:0] PN_DSL = 4'b1111;
    localparam logic [3:0] PN_NOP = 4'b0111;
    localparam logic [3:0] PN_ACT = 4'b0011;
    localparam logic [3:0] PN_RD  = 4'b0101;
    localparam logic [3:0] PN_WR  = 4'b0100;
    localparam logic [3:0] PN_PRE = 4'b0010;
    localparam logic [3:0] PN_MRS = 4'b0000;
    localparam logic [3:0] PN_REF = 4'b0001;
    localparam logic [3:0] PN_BAD = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        a10 = 1'b0;
    logic [1:0]  ba = '0;
    logic [14:0] cmd_vec;
    logic        cmd_err, ap_flag, dev_active, in_pwrdn, in_suspend, in_selfref, burst_busy;
    logic [3:0]  pre_mask, bank_open;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
        .cmd_vec(cmd_vec), .cmd_err(cmd_err), .ap_flag(ap_flag),
        .pre_mask(pre_mask), .bank_open(bank_open), .dev_active(dev_active),
        .in_pwrdn(in_pwrdn), .in_suspend(in_suspend), .in_selfref(in_selfref),
        .burst_busy(burst_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive pins at a falling edge, return at the next falling edge
    task automatic drive(input logic k, input logic [3:0] pins, input logic ap,
                         input logic [1:0] b);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = pins;
        a10 = ap;
        ba  = b;
        @(negedge clk);
    endtask

    task automatic idle_step();
        drive(1'b1, PN_DSL, 1'b0, 2'd0);
    endtask

    task automatic t_reset();
        chk("R11 cmd_vec", 32'(cmd_vec), 0);
        chk("R11 bank_open", 32'(bank_open), 0);
        chk("R11 flags", 32'({cmd_err, ap_flag, dev_active, in_pwrdn, in_suspend,
                              in_selfref, burst_busy}), 0);
        chk("R11 pre_mask", 32'(pre_mask), 0);
    endtask

    task automatic t_decode();
        idle_step();
        chk("R1 deselect", 32'(cmd_vec), 32'h1);
        drive(1'b1, PN_NOP, 1'b0, 2'd0);
        chk("R1 nop", 32'(cmd_vec), 32'h2);
        chk("R1 nop no err", 32'(cmd_err), 0);
        drive(1'b1, PN_BAD, 1'b0, 2'd1);
        chk("R2 bad code", 32'(cmd_vec), 32'h2);
        chk("R2 bad err", 32'(cmd_err), 1);
        chk("R2 bad no bank", 32'(bank_open), 0);
    endtask

    task automatic t_activate();
        drive(1'b1, PN_ACT, 1'b0, 2'd2);
        chk("R3 act code", 32'(cmd_vec), 32'h4);
        chk("R3 act bank", 32'(bank_open), 32'h4);
        chk("R3 active state", 32'(dev_active), 1);
        drive(1'b1, PN_ACT, 1'b0, 2'd2);
        chk("R3 act open err", 32'(cmd_err), 1);
        chk("R3 act open bank", 32'(bank_open), 32'h4);
    endtask

    task automatic t_rdwr();
        drive(1'b1, PN_RD, 1'b0, 2'd0);
        chk("R4 read closed code", 32'(cmd_vec), 32'h8);
        chk("R4 read closed err", 32'(cmd_err), 1);
        chk("R4 read closed burst", 32'(burst_busy), 0);
        drive(1'b1, PN_WR, 1'b0, 2'd2);
        chk("R4 write code", 32'(cmd_vec), 32'h10);
        chk("R4 write no ap", 32'(ap_flag), 0);
        chk("R4 write busy", 32'(burst_busy), 1);
        for (int i = 0; i < 3; i++) idle_step();
        chk("R6 burst last beat", 32'(burst_busy), 1);
        idle_step();
        chk("R6 burst done", 32'(burst_busy), 0);
        chk("R6 no ap keeps bank", 32'(bank_open), 32'h4);
        drive(1'b1, PN_RD, 1'b1, 2'd2);
        chk("R4 read ap flag", 32'(ap_flag), 1);
        drive(1'b1, PN_RD, 1'b0, 2'd2);
        chk("R4 read during ap err", 32'(cmd_err), 1);
        chk("R4 ap flag one cycle", 32'(ap_flag), 0);
        idle_step();
        idle_step();
        chk("R6 bank open before end", 32'(bank_open), 32'h4);
        idle_step();
        chk("R6 ap closes bank", 32'(bank_open), 0);
        chk("R6 back to idle", 32'(dev_active), 0);
    endtask

    task automatic t_precharge();
        drive(1'b1, PN_ACT, 1'b0, 2'd0);
        drive(1'b1, PN_ACT, 1'b0, 2'd3);
        chk("R3 two banks", 32'(bank_open), 32'h9);
        drive(1'b1, PN_PRE, 1'b0, 2'd3);
        chk("R5 single code", 32'(cmd_vec), 32'h20);
        chk("R5 single mask", 32'(pre_mask), 32'h8);
        chk("R5 single bank", 32'(bank_open), 32'h1);
        idle_step();
        chk("R5 mask clears", 32'(pre_mask), 0);
        drive(1'b1, PN_PRE, 1'b1, 2'd2);
        chk("R5 all mask", 32'(pre_mask), 32'hF);
        chk("R5 all banks", 32'(bank_open), 0);
    endtask

    task automatic t_mrs_ref();
        drive(1'b1, PN_ACT, 1'b0, 2'd1);
        drive(1'b1, PN_MRS, 1'b0, 2'd0);
        chk("R7 mrs busy err", 32'(cmd_err), 1);
        chk("R7 mrs keeps bank", 32'(bank_open), 32'h2);
        drive(1'b1, PN_REF, 1'b0, 2'd0);
        chk("R7 ref open err", 32'(cmd_err), 1);
        drive(1'b1, PN_PRE, 1'b1, 2'd0);
        drive(1'b1, PN_MRS, 1'b0, 2'd0);
        chk("R7 mrs code", 32'(cmd_vec), 32'h40);
        chk("R7 mrs ok", 32'(cmd_err), 0);
        drive(1'b1, PN_REF, 1'b0, 2'd0);
        chk("R7 ref code", 32'(cmd_vec), 32'h80);
        chk("R7 ref ok", 32'(cmd_err), 0);
    endtask

    task automatic t_selfref();
        drive(1'b0, PN_REF, 1'b0, 2'd0);
        chk("R8 entry code", 32'(cmd_vec), 32'h100);
        chk("R8 in selfref", 32'(in_selfref), 1);
        drive(1'b0, PN_DSL, 1'b0, 2'd0);
        chk("R10 hold code", 32'(cmd_vec), 32'h4000);
        idle_step();
        chk("R10 sref exit code", 32'(cmd_vec), 32'h200);
        chk("R10 sref exit idle", 32'({in_selfref, dev_active}), 0);
    endtask

    task automatic t_powerdown();
        drive(1'b1, PN_ACT, 1'b0, 2'd1);
        drive(1'b0, PN_REF, 1'b0, 2'd0);
        chk("R8 illegal sref err", 32'(cmd_err), 1);
        chk("R8 illegal sref pd code", 32'(cmd_vec), 32'h400);
        chk("R9 in pwrdn", 32'(in_pwrdn), 1);
        drive(1'b0, PN_DSL, 1'b0, 2'd0);
        chk("R10 pd hold", 32'(cmd_vec), 32'h4000);
        idle_step();
        chk("R10 pd exit code", 32'(cmd_vec), 32'h800);
        chk("R10 pd resumes active", 32'(dev_active), 1);
        chk("R10 pd banks kept", 32'(bank_open), 32'h2);
        drive(1'b0, PN_ACT, 1'b0, 2'd0);
        chk("R9 pd entry code", 32'(cmd_vec), 32'h400);
        chk("R9 command ignored", 32'(bank_open), 32'h2);
        chk("R9 ignored no err", 32'(cmd_err), 0);
        idle_step();
        chk("R10 pd exit again", 32'(in_pwrdn), 0);
    endtask

    task automatic t_suspend();
        drive(1'b1, PN_RD, 1'b0, 2'd1);
        chk("R4 read code", 32'(cmd_vec), 32'h8);
        drive(1'b1, PN_NOP, 1'b0, 2'd0);
        drive(1'b0, PN_NOP, 1'b0, 2'd0);
        chk("R9 suspend code", 32'(cmd_vec), 32'h1000);
        chk("R9 in suspend", 32'(in_suspend), 1);
        drive(1'b0, PN_DSL, 1'b0, 2'd0);
        drive(1'b0, PN_DSL, 1'b0, 2'd0);
        chk("R10 suspend hold", 32'(cmd_vec), 32'h4000);
        chk("R9 burst frozen", 32'(burst_busy), 1);
        idle_step();
        chk("R10 suspend exit code", 32'(cmd_vec), 32'h2000);
        chk("R10 suspend resumes active", 32'({in_suspend, dev_active}), 1);
        idle_step();
        chk("R9 burst still running", 32'(burst_busy), 1);
        idle_step();
        chk("R6 burst ends after resume", 32'(burst_busy), 0);
        chk("R6 no ap bank kept", 32'(bank_open), 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_decode();
        t_activate();
        t_rdwr();
        t_precharge();
        t_mrs_ref();
        t_selfref();
        t_powerdown();
        t_suspend();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule